// File: doc/BRIEF.md
# Scaled-Index Address Adder

This block forms addresses from a base and an index on a wide integer datapath. It scales one operand by 2, 4 or 8 and adds the other operand. It can first zero-extend the low half-word of the index, which lets 32-bit unsigned indices drive 64-bit address arithmetic. It also offers a plain add with a zero-extended index and a left shift of the zero-extended low half-word by an immediate. Every sum wraps modulo 2^XLEN. No carry or overflow indication is produced.

The operations exist only when the datapath runs in full-width mode. In narrow mode every request is flagged illegal and returns zero. The `LATENCY` parameter selects either a purely combinational path (0) or one output register stage with a valid bit (1).

Top module: `sasu_unit`

## Requirements
- R1: With op_i 0, 1 or 2 the result is (rs1_i << k) + rs2_i, where k is 1, 2 or 3, truncated to XLEN bits.
- R2: With op_i 3, 4 or 5 the result is (zext(rs1_i[XLEN/2-1:0]) << k) + rs2_i, where k is 1, 2 or 3. Upper bits of rs1_i have no effect.
- R3: With op_i 6 the result is zext(rs1_i[XLEN/2-1:0]) + rs2_i.
- R4: With op_i 7 and shamt_i < XLEN/2, the low half-word of rs1_i appears at bit position shamt_i and all other result bits are zero. rs2_i has no effect.
- R5: With op_i 7 and shamt_i >= XLEN/2, the result equals rs1_i << shamt_i.
- R6: shamt_i has no effect for op_i 0 to 6.
- R7: A valid request with wide_mode_i low sets illegal_o and drives result_o to zero, for every op_i.
- R8: The carry out of the top bit is dropped. Sums of maximal operands wrap.
- R9: With LATENCY 1, valid_o, illegal_o and result_o follow a request by one clock. While valid_o is low, result_o is zero and illegal_o is low.
- R10: After reset, valid_o, illegal_o and result_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used when LATENCY is 1) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request present |
| wide_mode_i | input | 1 | 1 = full-width mode, 0 = narrow mode |
| op_i | input | 3 | Operation select, encoding per R1 to R5 |
| rs1_i | input | XLEN | Index operand |
| rs2_i | input | XLEN | Base operand |
| shamt_i | input | $clog2(XLEN) | Immediate shift for op_i 7 |
| valid_o | output | 1 | Result present |
| illegal_o | output | 1 | Request rejected in narrow mode |
| result_o | output | XLEN | Address result |

## Verification
The bench builds the unit with XLEN 16 and LATENCY 1. At this size every low half-word value of the index can be swept for each scaled-add form. Each value is paired with base operands that force carries across the half-word boundary and out of the top bit. Every immediate from 0 to 15 is crossed with many index patterns, which covers both shift ranges and the boundary at 8. The narrow-mode rejection, the one-cycle timing and the idle zeroing are all checked at the same register stage.

// File: rtl/sasu_pkg.sv
package sasu_pkg;
  typedef enum logic [2:0] {
    OP_SH1ADD    = 3'd0,
    OP_SH2ADD    = 3'd1,
    OP_SH3ADD    = 3'd2,
    OP_SH1ADD_UW = 3'd3,
    OP_SH2ADD_UW = 3'd4,
    OP_SH3ADD_UW = 3'd5,
    OP_ADD_UW    = 3'd6,
    OP_SLLI_UW   = 3'd7
  } sasu_op_e;

  function automatic logic op_zext(sasu_op_e op);
    return op inside {OP_SH1ADD_UW, OP_SH2ADD_UW, OP_SH3ADD_UW, OP_ADD_UW, OP_SLLI_UW};
  endfunction

  function automatic logic op_adds(sasu_op_e op);
    return op != OP_SLLI_UW;
  endfunction
endpackage

// File: rtl/sasu_decode.sv
module sasu_decode
  import sasu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  sasu_op_e         op_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic             zext_o,
  output logic             add_o,
  output logic [SHW-1:0]   amt_o
);
  always_comb begin
    zext_o = op_zext(op_i);
    add_o  = op_adds(op_i);
    unique case (op_i)
      OP_SH1ADD, OP_SH1ADD_UW: amt_o = SHW'(1);
      OP_SH2ADD, OP_SH2ADD_UW: amt_o = SHW'(2);
      OP_SH3ADD, OP_SH3ADD_UW: amt_o = SHW'(3);
      OP_ADD_UW:               amt_o = '0;
      default:                 amt_o = shamt_i;
    endcase
  end
endmodule

// File: rtl/sasu_shifter.sv
module sasu_shifter #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] stage [SHW+1];
  assign stage[0] = data_i;
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stage[s+1] = amt_i[s] ? (stage[s] << (1 << s)) : stage[s];
  end
  assign data_o = stage[SHW];
endmodule

// File: rtl/sasu_adder.sv
module sasu_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] sum_o
);
  // carry out intentionally dropped
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/sasu_unit.sv
module sasu_unit
  import sasu_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int LATENCY = 1,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            wide_mode_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);
  sasu_op_e        op;
  logic            zext, use_add;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] src, shifted, addend, sum;
  logic            nxt_illegal;
  logic [XLEN-1:0] nxt_result;

  assign op = sasu_op_e'(op_i);

  sasu_decode #(.XLEN(XLEN)) u_dec (
    .op_i(op), .shamt_i(shamt_i), .zext_o(zext), .add_o(use_add), .amt_o(amt)
  );

  assign src    = zext ? {{(XLEN-HALF){1'b0}}, rs1_i[HALF-1:0]} : rs1_i;
  assign addend = use_add ? rs2_i : '0;

  sasu_shifter #(.XLEN(XLEN)) u_shf (.data_i(src), .amt_i(amt), .data_o(shifted));
  sasu_adder   #(.XLEN(XLEN)) u_add (.a_i(shifted), .b_i(addend), .sum_o(sum));

  assign nxt_illegal = valid_i & ~wide_mode_i;
  assign nxt_result  = (valid_i && wide_mode_i) ? sum : '0;

  if (LATENCY == 1) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o   <= 1'b0;
        illegal_o <= 1'b0;
        result_o  <= '0;
      end else begin
        valid_o   <= valid_i;
        illegal_o <= nxt_illegal;
        result_o  <= nxt_result;
      end
    end
  end else begin : g_comb
    assign valid_o   = valid_i;
    assign illegal_o = nxt_illegal;
    assign result_o  = nxt_result;
  end
endmodule

// File: rtl/sasu_checker.sv
module sasu_checker #(
  parameter int XLEN    = 64,
  parameter int LATENCY = 1,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            wide_mode_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [SHW-1:0]  shamt_i,
  input logic            valid_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] result_o
);
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && !illegal_o));

  assert_illegal_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0 && valid_o));

  if (LATENCY == 1) begin : g_seq
    assert_valid_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    assert_narrow_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !wide_mode_i) |=> illegal_o);
    assert_sh1add_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && wide_mode_i && op_i == 3'd0) |=>
      result_o == XLEN'(($past(rs1_i) << 1) + $past(rs2_i)));
    assert_add_uw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && wide_mode_i && op_i == 3'd6) |=>
      result_o == XLEN'({{(XLEN-HALF){1'b0}}, $past(rs1_i[HALF-1:0])} + $past(rs2_i)));
  end else begin : g_cmb
    assert_valid_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> valid_o);
    assert_narrow_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !wide_mode_i) |-> illegal_o);
    assert_sh1add_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && wide_mode_i && op_i == 3'd0) |->
      result_o == XLEN'((rs1_i << 1) + rs2_i));
    assert_add_uw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && wide_mode_i && op_i == 3'd6) |->
      result_o == XLEN'({{(XLEN-HALF){1'b0}}, rs1_i[HALF-1:0]} + rs2_i));
  end
endmodule

bind sasu_unit sasu_checker #(.XLEN(XLEN), .LATENCY(LATENCY)) u_chk (.*);

// File: tb/sasu_unit_test.sv
module sasu_unit_test;
  localparam int XLEN = 16;
  localparam int SHW  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0, wide_i = 1'b1;
  logic [2:0]      op_i = '0;
  logic [XLEN-1:0] rs1_i = '0, rs2_i = '0;
  logic [SHW-1:0]  shamt_i = '0;
  logic            valid_o, illegal_o;
  logic [XLEN-1:0] result_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sasu_unit #(.XLEN(XLEN), .LATENCY(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .wide_mode_i(wide_i),
    .op_i(op_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .shamt_i(shamt_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  function automatic logic [XLEN-1:0] model(int op, longint a, longint b, int sh);
    longint idx, r;
    idx = (op >= 3) ? (a % 256) : a;
    case (op)
      0, 3: r = idx * 2 + b;
      1, 4: r = idx * 4 + b;
      2, 5: r = idx * 8 + b;
      6:    r = idx + b;
      default: r = (sh < 8) ? (a % 256) * (longint'(1) << sh) : a * (longint'(1) << sh);
    endcase
    return XLEN'(r % 65536);
  endfunction

  task automatic check(string req, bit got_v, bit got_il, logic [XLEN-1:0] got_r,
                       bit exp_v, bit exp_il, logic [XLEN-1:0] exp_r);
    checks++;
    if (got_v !== exp_v || got_il !== exp_il || got_r !== exp_r) begin
      errors++;
      $display("FAIL %s: got v=%0b il=%0b r=%h expected v=%0b il=%0b r=%h",
               req, got_v, got_il, got_r, exp_v, exp_il, exp_r);
    end
  endtask

  // drives at a negedge, samples at the next negedge (one register stage)
  task automatic run(string req, int op, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                     int sh, bit wide, bit vld);
    logic [XLEN-1:0] exp;
    valid_i = vld; wide_i = wide; op_i = 3'(op); rs1_i = a; rs2_i = b; shamt_i = SHW'(sh);
    exp = (vld && wide) ? model(op, longint'(a), longint'(b), sh) : '0;
    @(negedge clk);
    check(req, valid_o, illegal_o, result_o, vld, vld && !wide, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [XLEN-1:0] bases [4] = '{16'h0000, 16'h00FF, 16'h8001, 16'hFFFF};
    repeat (2) @(negedge clk);
    check("R10", valid_o, illegal_o, result_o, 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", valid_o, illegal_o, result_o, 1'b0, 1'b0, '0);

    // R1 / R2 / R3 sweeps; shamt varies to probe R6
    for (int op = 0; op < 7; op++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 4; j++) begin
          logic [XLEN-1:0] a;
          a = {8'(i * 37 + j * 91), 8'(i)};
          run(op < 3 ? "R1" : (op < 6 ? "R2" : "R3"), op, a, bases[j], (i + j) % 16, 1'b1, 1'b1);
        end

    // R6: same operands, every shamt, identical result
    for (int op = 0; op < 7; op++)
      for (int sh = 0; sh < 16; sh++)
        run("R6", op, 16'hA5C3, 16'h1234, sh, 1'b1, 1'b1);

    // R4 / R5 sweep, rs2 must not matter
    for (int sh = 0; sh < 16; sh++)
      for (int i = 0; i < 256; i++)
        run(sh < 8 ? "R4" : "R5", 7, {8'(i * 13 + 5), 8'(i)}, 16'(i * 7 + 1), sh, 1'b1, 1'b1);
    run("R4", 7, 16'hFFFF, 16'hFFFF, 7, 1'b1, 1'b1);
    run("R5", 7, 16'hFFFF, 16'h0000, 8, 1'b1, 1'b1);

    // R8 wrap at the top
    run("R8", 2, 16'hFFFF, 16'hFFFF, 0, 1'b1, 1'b1);
    run("R8", 0, 16'h8000, 16'h8000, 0, 1'b1, 1'b1);
    run("R8", 6, 16'h00FF, 16'hFF01, 0, 1'b1, 1'b1);

    // R7 narrow mode rejects every op
    for (int op = 0; op < 8; op++)
      for (int sh = 0; sh < 16; sh += 5)
        run("R7", op, 16'hBEEF, 16'h1357, sh, 1'b0, 1'b1);

    // R9 idle cycles and back-to-back timing
    run("R9", 1, 16'h1111, 16'h2222, 0, 1'b1, 1'b0);
    run("R9", 1, 16'h1111, 16'h2222, 0, 1'b0, 1'b0);
    run("R9", 3, 16'hFF10, 16'h0003, 0, 1'b1, 1'b1);
    run("R9", 7, 16'h00AB, 16'hFFFF, 4, 1'b0, 1'b1);
    run("R9", 5, 16'h0001, 16'h0000, 0, 1'b1, 1'b1);
    run("R9", 5, 16'h0001, 16'h0000, 0, 1'b1, 1'b0);

    // R10 reset clears a live output
    run("R10", 0, 16'h0101, 16'h0001, 0, 1'b1, 1'b1);
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R10", valid_o, illegal_o, result_o, 1'b0, 1'b0, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule